// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns the single-bit output of a delta-sigma modulator into signed 16-bit samples at a lower rate. Every accepted bit counts as +1 or -1. The bits are summed by a chain of integrators that run at the modulator rate. Once per decimation window, a chain of differencing stages runs at the output rate. The filter shape is chosen at run time from four choices: a plain box average (first order), second order, third order, and a quick-settling variant. The quick-settling variant is the second-order response added to a copy of itself delayed by two output periods, and it is meant for fast overcurrent trips. The oversampling ratio is a power of two, OSR = 2^L, selected by the exponent L.

The scaled result is full scale when every bit is a one, and negative full scale when every bit is a zero. A one-cycle strobe marks each new word. A second one-cycle flag marks the first word whose whole impulse response lies inside data accepted since the last reset or the last configuration change. A typical user feeds the modulator clock and bit, picks second order or the quick variant for protection paths, picks third order with L = 8 for precise measurement, and ignores words until the flag has been seen.

Top module: `sinc_decimator`

## Requirements
- R1: `order_sel` encodes the response as follows: 0 is first order, 1 is second order, 2 is third order, 3 is the quick-settling variant. `osr_log2` is L, in the range 0..LMAX, and OSR = 2^L.
- R2: A bit is accepted on a rising edge where `bit_valid` is high and no restart occurs (R7). Bit 1 counts as +1 and bit 0 counts as -1. Word j is produced by the j·OSR-th accepted bit, and `word_valid` is high for exactly the one cycle that follows that edge.
- R3: For order k in 1..3, the unscaled result equals the convolution of the accepted ±1 values with the k-fold self-convolution of an OSR-long box of ones, where values before the run count as 0. This holds even after the integrators have wrapped around during long runs of a constant bit.
- R4: The quick-settling variant's unscaled result equals the second-order result of the current word plus the second-order result of two words earlier.
- R5: The scaled word is floor(r·2^15 / G), saturated to [-32768, 32767]. G is OSR^k for order k, and G is 2·OSR^2 for the quick variant. All ones gives 32767, all zeros gives -32768, and an alternating pattern gives 0.
- R6: `word_settled` pulses together with `word_valid` on the N-th word of a run and on no other word. N is 1, 2 or 3 for orders 1, 2 and 3, and N is 4 for the quick variant.
- R7: In any cycle where `order_sel` or `osr_log2` differs from the value in use, a new run starts. The history, the window phase and the word count are cleared, and the bit offered in that cycle is ignored, even when it would have completed a window.
- R8: While `rst_n` is low, `word_out`, `word_valid` and `word_settled` are all zero after each clock edge, and a new run starts afterwards.
- R9: `word_out` holds its value in every cycle where `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Modulator bit |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| order_sel | input | 2 | Response select (R1) |
| osr_log2 | input | $clog2(LMAX+1) | OSR exponent L |
| word_out | output | OUT_W | Signed scaled result |
| word_valid | output | 1 | One-cycle strobe per new word |
| word_settled | output | 1 | Marks the first fully settled word of a run |

## Verification
Two events can land in the same cycle: a change of configuration, and a bit that would close a decimation window. The bench provokes this by changing the quick variant's exponent right after 2^L−1 bits of a window have been accepted, while offering a valid bit in that cycle. It then judges that no strobe follows that edge and that the held word does not move. The following words must match a model that restarts from empty history. The settled flag also coincides with the strobe by design, and the bench checks on every word that the flag appears exactly on the word the model predicts for each order.

// File: rtl/sinc_pkg.sv
// Shared types and small helpers for the sinc decimator.
// Assumes the order encoding below is also what drives order_sel.
package sinc_pkg;

    typedef enum logic [1:0] {
        ORD_SINC1 = 2'd0,
        ORD_SINC2 = 2'd1,
        ORD_SINC3 = 2'd2,
        ORD_FAST  = 2'd3
    } sinc_order_e;

    // Words needed before the output reflects only post-restart data.
    function automatic logic [2:0] settle_words(input sinc_order_e o);
        case (o)
            ORD_SINC1: return 3'd1;
            ORD_SINC2: return 3'd2;
            ORD_SINC3: return 3'd3;
            default:   return 3'd4;
        endcase
    endfunction

    // log2 of the DC gain for a given order and OSR exponent.
    function automatic logic [7:0] gain_log2(input sinc_order_e o, input logic [7:0] l);
        case (o)
            ORD_SINC1: return l;
            ORD_SINC2: return 8'(l * 8'd2);
            ORD_SINC3: return 8'(l * 8'd3);
            default:   return 8'(l * 8'd2 + 8'd1);
        endcase
    endfunction

    // Integrator tap used by each order (the quick variant reuses order two).
    function automatic logic [1:0] tap_index(input sinc_order_e o);
        return (o == ORD_FAST) ? 2'd1 : 2'(o);
    endfunction

endpackage

// File: rtl/sinc_integ_bank.sv
// Cascade of running-sum integrators at the modulator rate.
// Each stage adds the updated sum of the stage before it in the same cycle,
// so stage k holds the exact k-fold cumulative sum through the newest bit.
// Arithmetic wraps modulo 2^ACC_W; the differencing stages cancel the wrap.
module sinc_integ_bank #(
    parameter int ACC_W  = 26,
    parameter int STAGES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           step,
    input  logic                           bit_in,
    output logic [STAGES-1:0][ACC_W-1:0]   sum_next
);

    logic [ACC_W-1:0] x_term;

    // Map the bit to +1 or -1 in two's complement.
    assign x_term = bit_in ? ACC_W'(1) : '1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [ACC_W-1:0] acc_r;
        logic [ACC_W-1:0] nxt;

        if (g == 0) begin : g_head
            assign nxt = acc_r + x_term;
        end else begin : g_tail
            assign nxt = acc_r + g_stage[g-1].nxt;
        end

        assign sum_next[g] = nxt;

        // Hold the running sum; cleared by reset or a restart.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc_r <= '0;
            end else if (step) begin
                acc_r <= nxt;
            end
        end
    end

endmodule

// File: rtl/sinc_comb_chain.sv
// Differencing stages at the decimated rate plus the two-word history used
// by the quick-settling variant. The result is combinational and valid in
// the cycle where fire is high; delay registers advance on that same edge.
// Assumes integ carries the integrator sums that include the current bit.
module sinc_comb_chain
    import sinc_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      fire,
    input  sinc_order_e               order,
    input  logic [7:0]                gexp,
    input  logic [2:0][ACC_W-1:0]     integ,
    output logic signed [ACC_W-1:0]   result
);

    logic [1:0]        tap;
    logic [ACC_W-1:0]  tap_val;
    logic [ACC_W-1:0]  hist1_r;
    logic [ACC_W-1:0]  hist2_r;

    assign tap     = tap_index(order);
    assign tap_val = integ[tap];

    for (genvar g = 0; g < 3; g++) begin : g_diff
        logic [ACC_W-1:0] din;
        logic [ACC_W-1:0] dly_r;
        logic [ACC_W-1:0] dout;

        if (g == 0) begin : g_head
            assign din = tap_val;
        end else begin : g_tail
            assign din = g_diff[g-1].dout;
        end

        assign dout = din - dly_r;

        // Remember this stage's input from the previous window.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                dly_r <= '0;
            end else if (fire) begin
                dly_r <= din;
            end
        end
    end

    // Second-order results of the last two windows for the quick variant.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist1_r <= '0;
            hist2_r <= '0;
        end else if (fire) begin
            hist1_r <= g_diff[1].dout;
            hist2_r <= hist1_r;
        end
    end

    // Pick the stage output that matches the selected order.
    always_comb begin
        case (tap)
            2'd0:    result = signed'(g_diff[0].dout);
            2'd1:    result = (order == ORD_FAST) ? signed'(g_diff[1].dout + hist2_r)
                                                  : signed'(g_diff[1].dout);
            default: result = signed'(g_diff[2].dout);
        endcase
    end

    logic signed [ACC_W-1:0] bound;
    assign bound = signed'(ACC_W'(1) << gexp);

    // R3: wrap-around in the integrators must cancel, leaving |r| within the gain.
    a_r3_within_gain: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (result <= bound) && (result >= -bound));

endmodule

// File: rtl/sinc_out_scale.sv
// Rescales the raw filter result so that the DC gain 2^gexp maps to 2^(OUT_W-1),
// rounding toward minus infinity, then saturates to the signed output range.
// Assumes |raw| <= 2^gexp and ACC_W > OUT_W.
module sinc_out_scale #(
    parameter int ACC_W = 26,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0]  raw,
    input  logic [7:0]               gexp,
    output logic signed [OUT_W-1:0]  word
);

    localparam int FRAC = OUT_W - 1;
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((64'sd1 <<< FRAC) - 64'sd1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

    logic signed [ACC_W-1:0] shifted;

    // Align the gain to the output full scale.
    always_comb begin
        if (gexp >= 8'(FRAC)) begin
            shifted = raw >>> (gexp - 8'(FRAC));
        end else begin
            shifted = raw <<< (8'(FRAC) - gexp);
        end
    end

    // Clamp into the signed output range.
    always_comb begin
        if (shifted > POS_LIM) begin
            word = POS_LIM[OUT_W-1:0];
        end else if (shifted < NEG_LIM) begin
            word = NEG_LIM[OUT_W-1:0];
        end else begin
            word = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/sinc_decimator.sv
// Top of the selectable-order sinc decimator. It tracks the configuration
// in use, restarts on any change, counts the window phase, registers the
// scaled word with a one-cycle strobe, and flags the first settled word.
// Assumes osr_log2 <= LMAX and a bit at most once per clock.
module sinc_decimator
    import sinc_pkg::*;
#(
    parameter int LMAX  = 8,
    parameter int OUT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_in,
    input  logic                         bit_valid,
    input  logic [1:0]                   order_sel,
    input  logic [$clog2(LMAX+1)-1:0]    osr_log2,
    output logic signed [OUT_W-1:0]      word_out,
    output logic                         word_valid,
    output logic                         word_settled
);

    localparam int ACC_W = 3 * LMAX + 2;
    localparam int LW    = $clog2(LMAX + 1);
    localparam int PH_W  = LMAX + 1;

    sinc_order_e               ord_q;
    logic [LW-1:0]             l_q;
    logic                      restart;
    logic                      accept;
    logic                      fire;
    logic [PH_W-1:0]           phase_r;
    logic [PH_W-1:0]           osr_m1;
    logic [2:0]                n_out_r;
    logic [7:0]                gexp;
    logic [2:0][ACC_W-1:0]     integ;
    logic signed [ACC_W-1:0]   raw;
    logic signed [OUT_W-1:0]   scaled;

    assign restart = (sinc_order_e'(order_sel) != ord_q) || (osr_log2 != l_q);
    assign accept  = bit_valid && !restart;
    assign osr_m1  = (PH_W'(1) << l_q) - PH_W'(1);
    assign fire    = accept && (phase_r == osr_m1);
    assign gexp    = gain_log2(ord_q, 8'(l_q));

    // Latch the configuration in use; a mismatch starts a new run.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ord_q <= sinc_order_e'(order_sel);
            l_q   <= osr_log2;
        end
    end

    // Position of the next accepted bit inside the decimation window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_r <= '0;
        end else if (accept) begin
            phase_r <= fire ? '0 : phase_r + PH_W'(1);
        end
    end

    // Words emitted in this run, saturating past the longest settle count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            n_out_r <= '0;
        end else if (fire && n_out_r < 3'd4) begin
            n_out_r <= n_out_r + 3'd1;
        end
    end

    sinc_integ_bank #(.ACC_W(ACC_W), .STAGES(3)) i_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .step     (accept),
        .bit_in   (bit_in),
        .sum_next (integ)
    );

    sinc_comb_chain #(.ACC_W(ACC_W)) i_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .fire   (fire),
        .order  (ord_q),
        .gexp   (gexp),
        .integ  (integ),
        .result (raw)
    );

    sinc_out_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_scale (
        .raw  (raw),
        .gexp (gexp),
        .word (scaled)
    );

    // Output word, strobe and settled flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out     <= '0;
            word_valid   <= 1'b0;
            word_settled <= 1'b0;
        end else begin
            word_valid   <= fire;
            word_settled <= fire && ((n_out_r + 3'd1) == settle_words(ord_q));
            if (fire) begin
                word_out <= scaled;
            end
        end
    end

    logic started_r;

    // Marks cycles whose previous sample already follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) started_r <= 1'b0;
        else        started_r <= 1'b1;
    end

    // R1: the exponent stays inside the supported range.
    a_r1_osr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(osr_log2) <= LMAX);

    // R2: every strobe follows an edge that carried a valid bit.
    a_r2_strobe_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bit_valid));

    // R2: with OSR above one, strobes never come back to back.
    a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && l_q != '0) |=> !word_valid);

    // R6: the settled flag only accompanies a strobe.
    a_r6_settle_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_settled |-> word_valid);

    // R7: a restart cycle never produces a word.
    a_r7_restart_silent: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !word_valid);

    // R9: the word only moves together with its strobe.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (started_r && !word_valid) |-> $stable(word_out));

endmodule

// File: tb/test_sinc_decimator.sv
// Bench: behavioural convolution model, compared with the outputs on every clock.
module test_sinc_decimator;

    localparam int CLK_PERIOD = 10;
    localparam int LMAX       = 8;

    logic               clk;
    logic               rst_n;
    logic               bit_in;
    logic               bit_valid;
    logic [1:0]         order_sel;
    logic [3:0]         osr_log2;
    logic signed [15:0] word_out;
    logic               word_valid;
    logic               word_settled;

    sinc_decimator #(.LMAX(LMAX), .OUT_W(16)) i_sinc_decimator (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .order_sel    (order_sel),
        .osr_log2     (osr_log2),
        .word_out     (word_out),
        .word_valid   (word_valid),
        .word_settled (word_settled)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    int      m_ord;
    int      m_l;
    int      hist[$];
    longint  coef[$];
    int      n_words;
    logic    exp_valid;
    logic    exp_settled;
    longint  exp_word;
    bit      restart_seen;
    longint  last_obs;
    int      words_seen;
    int      settle_idx;

    task automatic check(string tag, string what, longint got, longint expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // Impulse response of the selected filter, built by repeated box convolution.
    function automatic void build_coef();
        int osr = 1 << m_l;
        int reps = (m_ord == 0) ? 1 : (m_ord == 2) ? 3 : 2;
        longint base[$];
        base.push_back(1);
        for (int r = 0; r < reps; r++) begin
            longint nx[$];
            for (int n = 0; n < base.size() + osr - 1; n++) nx.push_back(0);
            for (int i = 0; i < base.size(); i++)
                for (int k = 0; k < osr; k++) nx[i+k] = nx[i+k] + base[i];
            base = nx;
        end
        if (m_ord == 3) begin
            longint f[$];
            for (int n = 0; n < base.size() + 2*osr; n++)
                f.push_back((n < base.size() ? base[n] : 0) +
                            (n >= 2*osr ? base[n-2*osr] : 0));
            base = f;
        end
        coef = base;
    endfunction

    function automatic longint model_raw();
        longint r = 0;
        int last = hist.size() - 1;
        for (int n = 0; n < coef.size(); n++)
            if (last - n >= 0) r += coef[n] * longint'(hist[last-n]);
        return r;
    endfunction

    function automatic longint model_scale(longint r);
        int e = (m_ord == 3) ? 2*m_l + 1 : (m_ord + 1) * m_l;
        longint s = (r * 32768) >>> e;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // Update the model for one rising edge.
    task automatic model_edge(input logic b, input logic v);
        int osr;
        int nset;
        if (int'(order_sel) != m_ord || int'(osr_log2) != m_l) begin
            m_ord = int'(order_sel);
            m_l   = int'(osr_log2);
            hist.delete();
            n_words = 0;
            build_coef();
            exp_valid    = 1'b0;
            exp_settled  = 1'b0;
            restart_seen = 1'b1;
            words_seen   = 0;
            settle_idx   = 0;
            return;
        end
        restart_seen = 1'b0;
        osr  = 1 << m_l;
        nset = (m_ord == 3) ? 4 : m_ord + 1;
        exp_valid   = 1'b0;
        exp_settled = 1'b0;
        if (v) begin
            hist.push_back(b ? 1 : -1);
            if (hist.size() % osr == 0) begin
                n_words++;
                exp_word    = model_scale(model_raw());
                exp_valid   = 1'b1;
                exp_settled = (n_words == nset);
            end
        end
    endtask

    task automatic compare();
        string vt = restart_seen ? "R7" : "R2";
        check(vt, "word_valid", longint'(word_valid), longint'(exp_valid));
        if (exp_valid) begin
            check((m_ord == 3) ? "R4" : "R1 R3", "word_out", longint'(word_out), exp_word);
            check("R6", "word_settled", longint'(word_settled), longint'(exp_settled));
        end else begin
            check("R9", "held word_out", longint'(word_out), exp_word);
            check("R6", "settled while idle", longint'(word_settled), 0);
        end
        if (word_valid) begin
            last_obs = longint'(word_out);
            words_seen++;
            if (word_settled) settle_idx = words_seen;
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare at the next fall.
    task automatic tick(input logic b, input logic v);
        bit_in    = b;
        bit_valid = v;
        @(posedge clk);
        model_edge(b, v);
        @(negedge clk);
        compare();
    endtask

    // Constant-density stream, optionally with idle cycles between bits.
    task automatic run(input int ord, input int l, input int dens, input int nbits, input bit gappy);
        int acc = 0;
        int sent = 0;
        int cyc = 0;
        order_sel = 2'(ord);
        osr_log2  = 4'(l);
        while (sent < nbits) begin
            logic v = gappy ? ((cyc % 3) != 2) : 1'b1;
            logic b = 1'b0;
            if (v) begin
                acc += dens;
                if (acc >= 100) begin
                    acc -= 100;
                    b = 1'b1;
                end
                sent++;
            end
            tick(b, v);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bit_in    = 1'b0;
        bit_valid = 1'b0;
        order_sel = 2'd2;
        osr_log2  = 4'd8;
        m_ord = 2;
        m_l   = 8;
        hist.delete();
        n_words = 0;
        build_coef();
        exp_word = 0;
        exp_valid = 1'b0;
        exp_settled = 1'b0;
        restart_seen = 1'b0;
        words_seen = 0;
        settle_idx = 0;
        last_obs = 0;
        repeat (3) @(negedge clk);
        check("R8", "reset word_out", longint'(word_out), 0);
        check("R8", "reset word_valid", longint'(word_valid), 0);
        check("R8", "reset word_settled", longint'(word_settled), 0);
        rst_n = 1'b1;

        // Third order, OSR 256, 80 percent ones.
        run(2, 8, 80, 6*256, 1'b0);
        check("R6", "third-order settle index", settle_idx, 3);

        // First order, OSR 16, alternating bits with idle gaps.
        run(0, 4, 50, 20*16, 1'b1);
        check("R6", "first-order settle index", settle_idx, 1);

        // Second order, OSR 32, 20 percent ones.
        run(1, 5, 20, 8*32, 1'b0);
        check("R6", "second-order settle index", settle_idx, 2);

        // Quick variant, OSR 16, all ones.
        run(3, 4, 100, 8*16, 1'b0);
        check("R5", "quick variant positive full scale", last_obs, 32767);
        check("R6", "quick variant settle index", settle_idx, 4);

        // Third order, OSR 64, all zeros.
        run(2, 6, 0, 6*64, 1'b0);
        check("R5", "negative full scale", last_obs, -32768);

        // Second order, OSR 16, alternating bits.
        run(1, 4, 50, 10*16, 1'b0);
        check("R5", "zero-input word", last_obs, 0);

        // Restart on the bit that would close a window.
        run(3, 3, 70, 23, 1'b0);
        run(3, 5, 70, 6*32, 1'b0);
        check("R7", "settle index after restart", settle_idx, 4);

        // Long all-ones run, integrators wrap many times.
        run(2, 8, 100, 40*256, 1'b0);
        check("R3", "wrapped integrators at full scale", last_obs, 32767);

        // OSR of one: every bit is a word.
        run(0, 0, 50, 10, 1'b1);

        bit_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule